// File: doc/BRIEF.md
# Iterative 64-bit SPN block encryptor with 80-bit key

This block encrypts one 64-bit block under an 80-bit key with a substitution-permutation network, one round per clock. A round adds the upper 64 bits of the key register, passes every nibble through a fixed 4-bit S-box, and scatters the bits with a fixed permutation. The key register then advances by rotation, one S-box on its top nibble and the round number mixed into five middle bits. After 31 rounds a last key addition gives the ciphertext.

Loading uses a key-first handshake. A one-cycle key strobe captures the key and arms the block. A following one-cycle plaintext strobe starts the run. The first round is computed directly from the plaintext input in the cycle of that strobe. The ciphertext is registered at the end of the last round. It is flagged with a one-cycle valid pulse and stays on the output until the next run completes. A new key must be supplied before every block, because the rounds consume the key register.

Top module: `spn64_enc`

## Requirements
- R1: While reset is active and after it is released, `ct_valid` is 0 and `ct_out` is all zeros.
- R2: In the idle state a `key_strobe` captures `key_in` and arms the block. A `text_strobe` in the idle state starts nothing, including when it comes in the same cycle as a `key_strobe`.
- R3: While armed, a further `key_strobe` without `text_strobe` replaces the captured key. A `text_strobe` starts encryption of `text_in` under the latest key.
- R4: Each round XORs the state with key register bits 79:16. It then maps every nibble x through S(x) = C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (hex, for x = 0..15). Finally it moves state bit i to bit (16*i mod 63) for i < 63, and keeps bit 63 in place.
- R5: After each round the key register is rotated left by 61 bits, its bits 79:76 pass through S, and bits 19:15 are XORed with the round number. The round number is 1 for the first round and rises by one per round.
- R6: After 31 rounds, `ct_out` becomes the state XORed with bits 79:16 of the once-more-updated key. `ct_valid` is first seen high 30 cycles after the clock edge that samples `text_strobe`.
- R7: `ct_valid` is high for exactly one cycle per block, and `ct_out` holds its value until the next block completes.
- R8: Both strobes are ignored while rounds are running. After completion the block is idle, so a lone `text_strobe` starts nothing.
- R9: An all-zero key with an all-zero plaintext gives ciphertext 5579C1387B228445 (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_in | input | 80 | Key value, sampled on `key_strobe` |
| key_strobe | input | 1 | One-cycle marker that `key_in` is valid |
| text_in | input | 64 | Plaintext, sampled on `text_strobe` |
| text_strobe | input | 1 | One-cycle marker that `text_in` is valid |
| ct_out | output | 64 | Ciphertext, held until the next completion |
| ct_valid | output | 1 | One-cycle pulse when `ct_out` is new |

## Verification
Two pairs of events can share one cycle: a key strobe and a plaintext strobe while idle, and either strobe with a round in progress. The first pair is provoked by raising both strobes together after reset. The bench then judges that no ciphertext appears within 40 cycles, and that a later lone plaintext strobe encrypts under that key. The second pair is provoked by injecting a different key and plaintext in the eleventh cycle of a run. The bench then checks that the ciphertext still matches the arithmetic model of the original inputs, and that the block came back idle.

// File: rtl/spn64_pkg.sv
package spn64_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN = 2'd2
  } ctl_st_t;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
      4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
      4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
      4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/spn64_round.sv
module spn64_round #(
  parameter int BLK_W = 64
) (
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  output logic [BLK_W-1:0] state_o
);
  localparam int NIBS = BLK_W / 4;
  localparam int MODV = BLK_W - 1;

  logic [BLK_W-1:0] mixed;
  logic [BLK_W-1:0] subst;

  assign mixed = state_i ^ rkey_i;

  for (genvar n = 0; n < NIBS; n++) begin : g_sbox
    assign subst[4*n +: 4] = spn64_pkg::sbox4(mixed[4*n +: 4]);
  end

  for (genvar b = 0; b < BLK_W - 1; b++) begin : g_perm
    localparam int DST = (b * NIBS) % MODV;
    assign state_o[DST] = subst[b];
  end
  assign state_o[BLK_W-1] = subst[BLK_W-1];

endmodule

// File: rtl/spn64_keysched.sv
module spn64_keysched #(
  parameter int KEY_W   = 80,
  parameter int ROT     = 61,
  parameter int CNT_W   = 5,
  parameter int CNT_LSB = 15
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [CNT_W-1:0] rnd_i,
  output logic [KEY_W-1:0] key_o
);
  localparam int LOW_W = KEY_W - ROT;

  logic [KEY_W-1:0] rotated;

  assign rotated = {key_i[LOW_W-1:0], key_i[KEY_W-1:LOW_W]};

  always_comb begin
    key_o = rotated;
    key_o[KEY_W-1 -: 4] = spn64_pkg::sbox4(rotated[KEY_W-1 -: 4]);
    key_o[CNT_LSB +: CNT_W] = rotated[CNT_LSB +: CNT_W] ^ rnd_i;
  end

endmodule

// File: rtl/spn64_ctrl.sv
module spn64_ctrl
  import spn64_pkg::*;
#(
  parameter int ROUNDS = 31,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_strobe,
  input  logic             text_strobe,
  output ctl_st_t          st_o,
  output logic [CNT_W-1:0] rnd_o,
  output logic             load_key_o,
  output logic             start_o,
  output logic             step_o,
  output logic             finish_o
);
  localparam logic [CNT_W-1:0] RND_FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] RND_LAST  = CNT_W'(ROUNDS);

  ctl_st_t          st_q, st_d;
  logic [CNT_W-1:0] rnd_q, rnd_d;

  always_comb begin
    load_key_o = 1'b0;
    start_o    = 1'b0;
    step_o     = 1'b0;
    finish_o   = 1'b0;
    st_d       = st_q;
    rnd_d      = rnd_q;
    case (st_q)
      ST_IDLE: begin
        if (key_strobe) begin
          load_key_o = 1'b1;
          st_d       = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (text_strobe) begin
          start_o = 1'b1;
          rnd_d   = rnd_q + CNT_W'(1);
          st_d    = ST_RUN;
        end else if (key_strobe) begin
          load_key_o = 1'b1;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        if (rnd_q == RND_LAST) begin
          finish_o = 1'b1;
          rnd_d    = RND_FIRST;
          st_d     = ST_IDLE;
        end else begin
          rnd_d = rnd_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = ST_IDLE;
        rnd_d = RND_FIRST;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rnd_q <= RND_FIRST;
    end else begin
      st_q  <= st_d;
      rnd_q <= rnd_d;
    end
  end

  assign st_o  = st_q;
  assign rnd_o = rnd_q;

endmodule

// File: rtl/spn64_enc.sv
module spn64_enc
  import spn64_pkg::*;
#(
  parameter int BLK_W  = 64,
  parameter int KEY_W  = 80,
  parameter int ROUNDS = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_in,
  input  logic             key_strobe,
  input  logic [BLK_W-1:0] text_in,
  input  logic             text_strobe,
  output logic [BLK_W-1:0] ct_out,
  output logic             ct_valid
);
  localparam int CNT_W = $clog2(ROUNDS + 1);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  ctl_st_t          st;
  logic [CNT_W-1:0] rnd;
  logic             load_key, start, step, finish;
  logic [BLK_W-1:0] state_q, round_in, round_out;
  logic [KEY_W-1:0] key_q, key_nxt;
  logic [BLK_W-1:0] ct_q;
  logic             vld_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  spn64_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .key_strobe  (key_strobe),
    .text_strobe (text_strobe),
    .st_o        (st),
    .rnd_o       (rnd),
    .load_key_o  (load_key),
    .start_o     (start),
    .step_o      (step),
    .finish_o    (finish)
  );

  // first round reads the plaintext port, later rounds the state register
  assign round_in = start ? text_in : state_q;

  spn64_round #(.BLK_W(BLK_W)) u_round (
    .state_i (round_in),
    .rkey_i  (key_q[KEY_W-1 -: BLK_W]),
    .state_o (round_out)
  );

  spn64_keysched #(.KEY_W(KEY_W), .ROT(61), .CNT_W(CNT_W), .CNT_LSB(15)) u_ksch (
    .key_i (key_q),
    .rnd_i (rnd),
    .key_o (key_nxt)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= '0;
    end else if (start || step) begin
      state_q <= round_out;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      key_q <= '0;
    end else if (load_key) begin
      key_q <= key_in;
    end else if (start || step) begin
      key_q <= key_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ct_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= finish;
      if (finish) ct_q <= round_out ^ key_nxt[KEY_W-1 -: BLK_W];
    end
  end

  assign ct_out   = ct_q;
  assign ct_valid = vld_q;

endmodule

// File: rtl/spn64_enc_chk.sv
module spn64_enc_chk
  import spn64_pkg::*;
#(
  parameter int BLK_W  = 64,
  parameter int ROUNDS = 31,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_strobe,
  input logic             text_strobe,
  input logic [BLK_W-1:0] ct_out,
  input logic             ct_valid,
  input ctl_st_t          st,
  input logic [CNT_W-1:0] rnd
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS);

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> (!ct_valid && ct_out == '0));

  a_r2_idle_text_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && text_strobe && !key_strobe) |=> st == ST_IDLE);

  a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && key_strobe) |=> st == ST_ARMED);

  a_r3_text_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED && text_strobe) |=> (st == ST_RUN && rnd == CNT_W'(2)));

  a_r5_first_round_one: assert property (@(posedge clk) disable iff (!rst_n)
    st != ST_RUN |-> rnd == CNT_W'(1));

  a_r5_round_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && rnd != LAST) |=> (st == ST_RUN && rnd == $past(rnd) + CNT_W'(1)));

  a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && rnd == LAST) |=> (ct_valid && st == ST_IDLE));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ct_valid |=> !ct_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ct_valid |-> $stable(ct_out));

  a_r8_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && rnd != LAST) |=> !ct_valid);

endmodule

bind spn64_enc spn64_enc_chk #(.BLK_W(BLK_W), .ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .key_strobe  (key_strobe),
  .text_strobe (text_strobe),
  .ct_out      (ct_out),
  .ct_valid    (ct_valid),
  .st          (st),
  .rnd         (rnd)
);

// File: tb/spn64_enc_test.sv
module spn64_enc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [79:0] key_in;
  logic        key_strobe;
  logic [63:0] text_in;
  logic        text_strobe;
  logic [63:0] ct_out;
  logic        ct_valid;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  spn64_enc uut (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_strobe(key_strobe),
    .text_in(text_in), .text_strobe(text_strobe), .ct_out(ct_out), .ct_valid(ct_valid)
  );

  function automatic logic [3:0] sb(input logic [3:0] x);
    logic [63:0] tbl = 64'h21_74_8F_E3_DA_09_B6_5C;
    return tbl[4*x +: 4];
  endfunction

  function automatic logic [63:0] model(input logic [79:0] k, input logic [63:0] p);
    logic [63:0] s, t;
    logic [79:0] kk;
    s = p;
    kk = k;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ kk[79:16];
      for (int n = 0; n < 16; n++) s[4*n +: 4] = sb(s[4*n +: 4]);
      t = '0;
      for (int i = 0; i < 63; i++) t[(i * 16) % 63] = s[i];
      t[63] = s[63];
      s = t;
      kk = {kk[18:0], kk[79:19]};
      kk[79:76] = sb(kk[79:76]);
      kk[19:15] = kk[19:15] ^ 5'(r);
    end
    return s ^ kk[79:16];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ct_valid) seen++;
    end
    check(seen == 0, tag, 64'(seen), 64'd0);
  endtask

  task automatic pulse_key(input logic [79:0] k);
    @(negedge clk); key_in = k; key_strobe = 1'b1;
    @(negedge clk); key_strobe = 1'b0;
  endtask

  task automatic run_text(input logic [79:0] k, input logic [63:0] p, input bit noise, input string tag);
    logic [63:0] exp;
    logic [63:0] held;
    int n;
    bit seen;
    exp = model(k, p);
    text_in = p; text_strobe = 1'b1;
    @(negedge clk); text_strobe = 1'b0; text_in = ~p;
    n = 0; seen = 1'b0;
    while (!seen && n < 60) begin
      if (noise && n == 10) begin
        key_in = ~k; key_strobe = 1'b1; text_strobe = 1'b1;
      end
      @(negedge clk);
      key_strobe = 1'b0; text_strobe = 1'b0;
      n++;
      if (ct_valid) seen = 1'b1;
    end
    check(seen && n == 30, "R6 latency", 64'(n), 64'd30);
    check(ct_out == exp, tag, ct_out, exp);
    held = ct_out;
    @(negedge clk);
    check(!ct_valid, "R7 valid single cycle", 64'(ct_valid), 64'd0);
    repeat (5) @(negedge clk);
    check(ct_out == held, "R7 ciphertext held", ct_out, held);
  endtask

  task automatic enc(input logic [79:0] k, input logic [63:0] p, input bit noise, input string tag);
    pulse_key(k);
    run_text(k, p, noise, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [79:0] kr;
    logic [63:0] pr;
    logic [63:0] x;
    rst_n = 1'b0; key_in = '0; key_strobe = 1'b0; text_in = '0; text_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check(!ct_valid && ct_out == '0, "R1 during reset", ct_out, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!ct_valid && ct_out == '0, "R1 after reset", ct_out, 64'd0);

    // R2: plaintext strobe while idle
    text_in = 64'h1234; text_strobe = 1'b1;
    @(negedge clk); text_strobe = 1'b0;
    quiet("R2 idle text ignored");

    // R2: both strobes together while idle: key taken, no start
    key_in = 80'h0123_4567_89AB_CDEF_F00D; key_strobe = 1'b1;
    text_in = 64'hDEAD; text_strobe = 1'b1;
    @(negedge clk); key_strobe = 1'b0; text_strobe = 1'b0;
    quiet("R2 same-cycle strobes start nothing");
    run_text(80'h0123_4567_89AB_CDEF_F00D, 64'hCAFE_F00D_0000_1111, 1'b0, "R2 key kept from joint strobe");

    // R9 and fixed vectors
    enc('0, '0, 1'b0, "R9 zero vector");
    check(ct_out == 64'h5579C1387B228445, "R9 literal", ct_out, 64'h5579C1387B228445);
    enc({80{1'b1}}, '0, 1'b0, "R4 R5 ones key");
    check(ct_out == 64'hE72C46C0F5945049, "R5 ones key literal", ct_out, 64'hE72C46C0F5945049);
    enc('0, {64{1'b1}}, 1'b0, "R4 ones text");
    check(ct_out == 64'hA112FFC72F68417B, "R4 ones text literal", ct_out, 64'hA112FFC72F68417B);

    // R3: key replaced while armed
    pulse_key(80'hAAAA_BBBB_CCCC_DDDD_EEEE);
    pulse_key(80'h1111_2222_3333_4444_5555);
    run_text(80'h1111_2222_3333_4444_5555, 64'h0F0F_F0F0_3C3C_C3C3, 1'b0, "R3 second key wins");

    // R8: strobes during a run
    enc(80'h9876_5432_10FE_DCBA_1357, 64'h2468_ACE0_1357_9BDF, 1'b1, "R8 run immune to strobes");
    text_in = 64'h55; text_strobe = 1'b1;
    @(negedge clk); text_strobe = 1'b0;
    quiet("R8 idle after run");

    // sweep of patterned keys and texts
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int v = 0; v < 24; v++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      kr = {x[15:0], x};
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      pr = (v % 4 == 0) ? (64'd1 << v) : x;
      enc(kr, pr, 1'b0, "R4 R5 R6 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule